// File: doc/BRIEF.md
# Single-Cycle Sequential 32-bit Processor Core

This block is a small 32-bit processor core that completes one instruction on every clock edge. Instructions have variable length and are encoded in bytes. Each one is broken down into the same set of stage values: the opcode and function nibbles, two register fields, a constant, the fall-through address, two source operands, an execute result and a loaded word. The core then passes through the stages in a fixed order: fetch, decode, execute, memory, write-back and next-PC selection. Because of this, every instruction type runs on one shared datapath and differs only in which values it selects.

Code and data share one internal byte array. While the core is held in reset, a byte-wide load port fills that array. After reset is released, the core runs until it meets a halt instruction or an unknown opcode, and then freezes with a status code. Every instruction that executes, including the one that stops the core, produces a one-cycle retire pulse that carries its address. A combinational peek port exposes any of the eight general registers so that results can be observed.

Top module: `seq_core`

## Requirements
- R1: While reset is low, the core holds these values: `pc` = 0, `status` = 0 (running), every register = 0, and `flags` = 3'b100. The flags bits are ordered {zero, sign, overflow}, so this value has only the zero flag set.
- R2: The first byte of each instruction is {opcode[7:4], function[3:0]}. After a non-branching instruction the PC advances by the instruction length. Lengths are 1 byte for opcodes 0, 1 and 9; 2 bytes for opcodes 2, 6, A and B; 5 bytes for opcodes 7 and 8; and 6 bytes for opcodes 3, 4 and 5.
- R3: Opcode 3 (layout `30 F rB c0 c1 c2 c3`) writes the little-endian constant into rB. Opcode 2 with function 0 (layout `20 rA rB`) copies rA into rB. In the second byte, rA occupies the upper nibble and rB the lower nibble.
- R4: Opcode 6 computes rB := rB op rA. The operation is selected by the function code: 0 add, 1 subtract (rB minus rA), 2 bitwise and, 3 bitwise xor.
- R5: Only opcode 6 updates the flags. The zero flag is set when the result is 0. The sign flag is result bit 31. The overflow flag is the signed overflow of an add or subtract, and is 0 for and/xor. All other instructions leave the flags unchanged.
- R6: Opcode 7 jumps to its little-endian 4-byte target when the condition selected by its function code holds, and otherwise falls through. The conditions are 0 always, 1 le ((S^O)|Z), 2 l (S^O), 3 e (Z), 4 ne (!Z), 5 ge (!(S^O)) and 6 g (!(S^O)&!Z).
- R7: Opcode 2 with a function code from 1 to 6 is a conditional move. It uses the same conditions as R6 and writes rB only when its condition holds.
- R8: Opcode 4 stores rA as 4 little-endian bytes at rB + constant. Opcode 5 loads 4 little-endian bytes from rB + constant into rA.
- R9: Push (opcode A) decrements register 4 by 4, then stores rA at the new address. Pop (opcode B) loads from the old register 4 value and increments register 4 by 4. When pop names register 4 as its destination, the loaded word wins.
- R10: Call (opcode 8) pushes its fall-through address and jumps to its constant. Return (opcode 9) pops the next PC from the stack.
- R11: Register ID F means "no register". A write to F is dropped, and a read of F returns 0.
- R12: Opcode 0 sets `status` to 1 (halted). From then on `pc` keeps the halt instruction's address and no further instruction retires.
- R13: The core sets `status` to 2 and freezes like a halt when it meets any of the following: an opcode above B, opcode 6 with a function code above 3, or opcode 2 or 7 with a function code above 6.
- R14: Each executed instruction, including the one that halts or faults, raises `retire_valid` for one cycle after its clock edge, with `retire_pc` set to that instruction's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Write one byte into the memory array |
| ld_addr | input | log2(MEM_BYTES) | Byte address for the load port |
| ld_data | input | 8 | Byte to write |
| dbg_sel | input | 3 | Register selected for peeking |
| dbg_val | output | 32 | Value of the selected register |
| status | output | 2 | 0 running, 1 halted, 2 invalid opcode |
| pc | output | 32 | Address of the next instruction to execute |
| flags | output | 3 | Flags {zero, sign, overflow} |
| retire_valid | output | 1 | Pulse for each executed instruction |
| retire_pc | output | 32 | Address of the instruction that just retired |

## Verification
The assertions assume three things about the inputs. First, the memory is fully written before reset is released. Second, the load port stays idle while the core runs. Third, every address a program touches falls inside the array, so a return always reads defined bytes.

The bench meets these assumptions as follows. It zeroes the whole array and loads each program while reset is held, then releases reset only once the program is in place. The programs keep the stack and all data well inside the array. Each program ends in a halt or an invalid opcode before any index could wrap.

// File: rtl/seq_core.sv
module seq_core #(
  parameter int MEM_BYTES = 256,
  parameter int AW = $clog2(MEM_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [7:0]    ld_data,
  input  logic [2:0]    dbg_sel,
  output logic [31:0]   dbg_val,
  output logic [1:0]    status,
  output logic [31:0]   pc,
  output logic [2:0]    flags,
  output logic          retire_valid,
  output logic [31:0]   retire_pc
);
  localparam logic [1:0] ST_AOK = 2'd0;
  localparam logic [1:0] ST_HLT = 2'd1;
  localparam logic [1:0] ST_INS = 2'd2;
  localparam logic [3:0] RNONE  = 4'hF;
  localparam logic [3:0] RSP    = 4'h4;

  logic [7:0]  mem [MEM_BYTES];
  logic [31:0] rf  [8];
  logic [31:0] pc_q;
  logic [2:0]  cc_q;
  logic [1:0]  st_q;

  function automatic logic [31:0] rd(input logic [3:0] id, input logic [31:0] r [8]);
    return id[3] ? 32'd0 : r[id[2:0]];
  endfunction

  function automatic logic cond_ok(input logic [3:0] fn, input logic [2:0] f);
    logic z, s, o;
    z = f[2]; s = f[1]; o = f[0];
    case (fn)
      4'd0: return 1'b1;
      4'd1: return (s ^ o) | z;
      4'd2: return s ^ o;
      4'd3: return z;
      4'd4: return !z;
      4'd5: return !(s ^ o);
      4'd6: return !(s ^ o) && !z;
      default: return 1'b0;
    endcase
  endfunction

  // fetch
  logic [7:0] fb [6];
  always_comb
    for (int k = 0; k < 6; k++) fb[k] = mem[pc_q[AW-1:0] + AW'(k)];

  wire [3:0] icode = fb[0][7:4];
  wire [3:0] ifun  = fb[0][3:0];
  wire need_reg = icode inside {4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'hA, 4'hB};
  wire [3:0] rA = need_reg ? fb[1][7:4] : RNONE;
  wire [3:0] rB = need_reg ? fb[1][3:0] : RNONE;
  wire [31:0] valC = need_reg ? {fb[5], fb[4], fb[3], fb[2]} : {fb[4], fb[3], fb[2], fb[1]};

  logic [2:0] ilen;
  always_comb
    case (icode)
      4'h2, 4'h6, 4'hA, 4'hB: ilen = 3'd2;
      4'h7, 4'h8:             ilen = 3'd5;
      4'h3, 4'h4, 4'h5:       ilen = 3'd6;
      default:                ilen = 3'd1;
    endcase
  wire [31:0] valP = pc_q + {29'd0, ilen};

  wire ins_ok = (icode <= 4'hB) &&
                !(icode == 4'h6 && ifun > 4'd3) &&
                !((icode == 4'h2 || icode == 4'h7) && ifun > 4'd6);
  wire running = (st_q == ST_AOK);
  wire exec    = running && ins_ok && (icode != 4'h0);

  // decode
  logic [3:0] srcA, srcB;
  always_comb begin
    case (icode)
      4'h2, 4'h4, 4'h6, 4'hA: srcA = rA;
      4'h9, 4'hB:             srcA = RSP;
      default:                srcA = RNONE;
    endcase
    case (icode)
      4'h4, 4'h5, 4'h6:       srcB = rB;
      4'h8, 4'h9, 4'hA, 4'hB: srcB = RSP;
      default:                srcB = RNONE;
    endcase
  end
  wire [31:0] valA = rd(srcA, rf);
  wire [31:0] valB = rd(srcB, rf);

  // execute
  logic [31:0] alu_r;
  logic        alu_of;
  always_comb begin
    alu_of = 1'b0;
    case (ifun[1:0])
      2'd0: begin
        alu_r  = valB + valA;
        alu_of = (valA[31] == valB[31]) && (alu_r[31] != valA[31]);
      end
      2'd1: begin
        alu_r  = valB - valA;
        alu_of = (valA[31] != valB[31]) && (alu_r[31] != valB[31]);
      end
      2'd2: alu_r = valB & valA;
      default: alu_r = valB ^ valA;
    endcase
  end
  wire [2:0] cc_new = {alu_r == 32'd0, alu_r[31], alu_of};
  wire       cnd    = cond_ok(ifun, cc_q);

  logic [31:0] valE;
  always_comb
    case (icode)
      4'h2:       valE = valA;
      4'h3:       valE = valC;
      4'h4, 4'h5: valE = valB + valC;
      4'h6:       valE = alu_r;
      4'h8, 4'hA: valE = valB - 32'd4;
      4'h9, 4'hB: valE = valB + 32'd4;
      default:    valE = 32'd0;
    endcase

  // memory
  wire [31:0] maddr = (icode == 4'h9 || icode == 4'hB) ? valA : valE;
  wire [31:0] valM  = {mem[maddr[AW-1:0] + AW'(3)], mem[maddr[AW-1:0] + AW'(2)],
                       mem[maddr[AW-1:0] + AW'(1)], mem[maddr[AW-1:0]]};
  wire        mwr   = exec && (icode == 4'h4 || icode == 4'h8 || icode == 4'hA);
  wire [31:0] wdata = (icode == 4'h8) ? valP : valA;

  always_ff @(posedge clk)
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (rst_n && mwr)
      for (int k = 0; k < 4; k++) mem[valE[AW-1:0] + AW'(k)] <= wdata[8*k +: 8];

  // write-back
  logic [3:0] dstE, dstM;
  always_comb begin
    case (icode)
      4'h2:                   dstE = cnd ? rB : RNONE;
      4'h3, 4'h6:             dstE = rB;
      4'h8, 4'h9, 4'hA, 4'hB: dstE = RSP;
      default:                dstE = RNONE;
    endcase
    dstM = (icode == 4'h5 || icode == 4'hB) ? rA : RNONE;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int k = 0; k < 8; k++) rf[k] <= 32'd0;
    end else if (exec) begin
      if (!dstE[3]) rf[dstE[2:0]] <= valE;
      if (!dstM[3]) rf[dstM[2:0]] <= valM;
    end

  // PC update, flags and status
  logic [31:0] pc_nx;
  always_comb
    case (icode)
      4'h7:    pc_nx = cnd ? valC : valP;
      4'h8:    pc_nx = valC;
      4'h9:    pc_nx = valM;
      default: pc_nx = valP;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pc_q         <= 32'd0;
      cc_q         <= 3'b100;
      st_q         <= ST_AOK;
      retire_valid <= 1'b0;
      retire_pc    <= 32'd0;
    end else begin
      retire_valid <= running;
      if (running) retire_pc <= pc_q;
      if (running && !ins_ok)            st_q <= ST_INS;
      else if (running && icode == 4'h0) st_q <= ST_HLT;
      if (exec) pc_q <= pc_nx;
      if (exec && icode == 4'h6) cc_q <= cc_new;
    end

  assign pc      = pc_q;
  assign flags   = cc_q;
  assign status  = st_q;
  assign dbg_val = rf[dbg_sel];

  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_AOK) |=> ($stable(pc_q) && $stable(st_q) && !retire_valid)); // R12
  AST_CC_ONLY_ALU: assert property (@(posedge clk) disable iff (!rst_n)
    (running && icode != 4'h6) |=> $stable(cc_q)); // R5
  AST_PUSH_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (running && icode == 4'hA && rA != RSP) |=> (rf[4] == $past(rf[4]) - 32'd4)); // R9
  AST_RET_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (running && icode == 4'h9) |=> (pc_q == $past(valM))); // R10
  AST_NOP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (running && icode == 4'h1) |=> (pc_q == $past(pc_q) + 32'd1)); // R2
  AST_BAD_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !ins_ok) |=> (st_q == ST_INS)); // R13
  AST_RETIRE_PC: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> (retire_valid && retire_pc == $past(pc_q))); // R14
endmodule

// File: tb/seq_core_tb.sv
module seq_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MEMB = 256;
  localparam int AW = $clog2(MEMB);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic [2:0] dbg_sel = '0;
  logic [31:0] dbg_val, pc, retire_pc;
  logic [1:0] status;
  logic [2:0] flags;
  logic retire_valid;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int la = 0;
  logic [31:0] exp_pc[$];
  string exp_tag[$];

  seq_core #(.MEM_BYTES(MEMB)) dut_i (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .dbg_sel(dbg_sel), .dbg_val(dbg_val), .status(status), .pc(pc), .flags(flags),
    .retire_valid(retire_valid), .retire_pc(retire_pc));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected <20000 cycles", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  // monitor: pops expected retire addresses
  always @(negedge clk)
    if (rst_n && retire_valid) begin
      if (exp_pc.size() == 0) chk("R12 retire after stop", retire_pc, 32'hFFFFFFFF);
      else begin
        logic [31:0] e;
        string t;
        e = exp_pc.pop_front();
        t = exp_tag.pop_front();
        chk(t, retire_pc, e);
      end
    end

  task automatic expect_pc(input logic [31:0] a, input string tag);
    exp_pc.push_back(a);
    exp_tag.push_back(tag);
  endtask

  task automatic w8(input logic [7:0] b);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = AW'(la); ld_data = b;
    la++;
  endtask
  task automatic w32(input logic [31:0] v);
    for (int k = 0; k < 4; k++) w8(v[8*k +: 8]);
  endtask
  task automatic org(input int a);
    la = a;
  endtask
  task automatic clear_mem();
    la = 0;
    for (int k = 0; k < MEMB; k++) w8(8'h00);
  endtask
  task automatic finish_load();
    @(negedge clk);
    ld_en = 1'b0;
  endtask
  task automatic peek(input logic [2:0] r, input logic [31:0] exp, input string tag);
    @(negedge clk);
    dbg_sel = r;
    #1;
    chk(tag, dbg_val, exp);
  endtask
  task automatic run_to_stop();
    while (status == 2'd0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 pc", pc, 32'd0);
    chk("R1 status", {30'd0, status}, 32'd0);
    chk("R1 flags", {29'd0, flags}, 32'd4);
    peek(3'd0, 32'd0, "R1 r0");
    peek(3'd7, 32'd0, "R1 r7");

    // program 1
    clear_mem();
    org(0);  w8(8'h30); w8(8'hF4); w32(32'h100);
    org(6);  w8(8'h30); w8(8'hF0); w32(32'h12345678);
    org(12); w8(8'h30); w8(8'hF1); w32(32'd10);
    org(18); w8(8'h30); w8(8'hF2); w32(32'd3);
    org(24); w8(8'h20); w8(8'h03);
    org(26); w8(8'h60); w8(8'h21);
    org(28); w8(8'h61); w8(8'h12);
    org(30); w8(8'h72); w32(32'd40);
    org(40); w8(8'h10);
    org(41); w8(8'h25); w8(8'h05);
    org(43); w8(8'h22); w8(8'h16);
    org(45); w8(8'h62); w8(8'h11);
    org(47); w8(8'h63); w8(8'h11);
    org(49); w8(8'h73); w32(32'd59);
    org(59); w8(8'h74); w32(32'd0);
    org(64); w8(8'h40); w8(8'h01); w32(32'h80);
    org(70); w8(8'h50); w8(8'h71); w32(32'h7E);
    org(76); w8(8'hA0); w8(8'h6F);
    org(78); w8(8'h80); w32(32'd90);
    org(83); w8(8'hB0); w8(8'h5F);
    org(85); w8(8'hA0); w8(8'h0F);
    org(87); w8(8'hB0); w8(8'h4F);
    org(89); w8(8'h00);
    org(90); w8(8'h30); w8(8'hFF); w32(32'h55);
    org(96); w8(8'h20); w8(8'hF3);
    org(98); w8(8'h90);
    finish_load();

    expect_pc(0, "R2 irmov"); expect_pc(6, "R2 len6"); expect_pc(12, "R2 len6");
    expect_pc(18, "R2 len6"); expect_pc(24, "R2 len6"); expect_pc(26, "R2 len2");
    expect_pc(28, "R2 len2"); expect_pc(30, "R2 len2");
    expect_pc(40, "R6 jl taken"); expect_pc(41, "R2 nop len1");
    expect_pc(43, "R2 cmov len2"); expect_pc(45, "R2"); expect_pc(47, "R2");
    expect_pc(49, "R2"); expect_pc(59, "R6 je taken");
    expect_pc(64, "R6 jne not taken"); expect_pc(70, "R2 len6");
    expect_pc(76, "R2 len6"); expect_pc(78, "R2 push len2");
    expect_pc(90, "R10 call target"); expect_pc(96, "R2");
    expect_pc(98, "R2"); expect_pc(83, "R10 ret target");
    expect_pc(85, "R14"); expect_pc(87, "R14"); expect_pc(89, "R14 halt retires");

    @(negedge clk);
    rst_n = 1'b1;
    run_to_stop();
    chk("R12 status halted", {30'd0, status}, 32'd1);
    chk("R12 pc holds", pc, 32'd89);
    chk("R14 all retired", exp_pc.size(), 32'd0);
    chk("R5 flags after xor", {29'd0, flags}, 32'd4);
    peek(3'd0, 32'h12345678, "R3 irmov r0");
    peek(3'd1, 32'd0, "R4 xor r1");
    peek(3'd2, 32'hFFFFFFF6, "R4 sub r2");
    peek(3'd3, 32'd0, "R11 read F, write F dropped");
    peek(3'd4, 32'h12345678, "R9 pop esp");
    peek(3'd5, 32'd13, "R9 pop r5, R7 cmovge not taken before");
    peek(3'd6, 32'd13, "R7 cmovl taken");
    peek(3'd7, 32'h56780000, "R8 store then load");

    // program 2
    @(negedge clk);
    rst_n = 1'b0;
    clear_mem();
    org(0);  w8(8'h30); w8(8'hF0); w32(32'h7FFFFFFF);
    org(6);  w8(8'h30); w8(8'hF1); w32(32'd1);
    org(12); w8(8'h60); w8(8'h10);
    org(14); w8(8'h71); w32(32'd30);
    org(19); w8(8'hC0);
    finish_load();
    expect_pc(0, "R14 p2"); expect_pc(6, "R2 p2"); expect_pc(12, "R2 p2");
    expect_pc(14, "R2 p2"); expect_pc(19, "R6 jle not taken");
    @(negedge clk);
    rst_n = 1'b1;
    run_to_stop();
    chk("R13 status invalid", {30'd0, status}, 32'd2);
    chk("R13 pc holds", pc, 32'd19);
    chk("R5 overflow flags", {29'd0, flags}, 32'd3);
    chk("R14 p2 retired", exp_pc.size(), 32'd0);
    peek(3'd0, 32'h80000000, "R4 add overflow");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule